// File: doc/BRIEF.md
# Streaming 3x3 Laplacian Edge Filter (Distributed Arithmetic)

The block takes a raster-order stream of unsigned pixels, one per clock when `pix_vld_i` is high, and produces one filtered value for each accepted pixel. The filter is the 8-neighbour Laplacian: the centre pixel is weighted by 8 and every surrounding pixel by -1. The two previous image rows live in shift-register line stores, so no pixel is fetched twice. A register stage turns the three vertically aligned pixels into a window column, and a 3x3 register window slides across the row.

The convolution uses no multipliers. For each bit plane, the same bit of all nine window pixels forms a 9-bit address. A lookup function returns the kernel's partial sum for that address. The eight plane sums are then combined by a pipelined tree, and each tree level scales its upper operand by a left shift. The result is signed and 4 bits wider than a pixel. Per pixel, the result can instead be returned as an absolute value clamped to the pixel range. `sof_i` marks the first pixel of a frame and restarts the row and column count.

Top module: `lap_da_filter`

## Requirements
- R1: For an interior output, `res_o` in signed mode equals 8 times the window centre minus the sum of its eight neighbours. It is a two's-complement value `PIX_W+4` bits wide.
- R2: Rows and columns are counted from the pixel that came with `sof_i`. The column wraps to 0 after `LINE_W-1` and the row then increments. The result for the pixel at row r, column c is the kernel centred at row r-1, column c-1.
- R3: The result is zero when r < 2 or c < 2.
- R4: Each accepted pixel yields exactly one result, and results keep input order. A pixel sampled at clock edge k has its result presented with `res_vld_o` high after edge k+5.
- R5: Clock cycles with `pix_vld_i` low advance neither the line stores, the window nor the position count. Results match those of the same pixels sent without gaps.
- R6: `res_o` is zero whenever `res_vld_o` is low.
- R7: `abs_mode_i` is sampled together with each pixel. When it is 1, that pixel's result is min(|L|, 2^PIX_W-1), zero-extended, where L is the R1 value.
- R8: `res_sof_o` is high exactly with the result of a pixel that arrived with `sof_i`. A `sof_i` in mid-row restarts counting at row 0, column 0.
- R9: Extreme windows do not wrap. A 255 centre with zero neighbours gives +2040, and a zero centre with 255 neighbours gives -2040. In absolute mode both give 255.
- R10: During and right after reset, `res_vld_o` and `res_sof_o` are low and `res_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | Pixel accepted this cycle |
| pix_i | input | PIX_W | Unsigned pixel value |
| sof_i | input | 1 | First pixel of a frame (qualified by `pix_vld_i`) |
| abs_mode_i | input | 1 | Return the clamped magnitude for this pixel |
| res_vld_o | output | 1 | Result valid |
| res_sof_o | output | 1 | Result belongs to a frame's first pixel |
| res_o | output | PIX_W+4 | Filtered value, signed or clamped magnitude |

## Verification
The assertions take for granted that every frame starts with a pixel carrying `sof_i`, and that rows are exactly `LINE_W` accepted pixels long. Frame height is free. The range and border properties also rely on `pix_i` being an unsigned value in `PIX_W` bits. The stimulus keeps within these limits: every frame opens with `sof_i`, and a frame is only cut short by a new `sof_i` that restarts counting. Pixel values come from an 8-bit generator. Idle gaps are inserted between pixels without ever splitting the meaning of a row.

// File: rtl/lap_da_pkg.sv
package lap_da_pkg;

  localparam int TAPS   = 9;
  localparam int CENTRE = 4;

  // Per-pixel control carried alongside the datapath
  typedef struct packed {
    logic vld;
    logic sof;
    logic zero;
    logic abs_m;
  } tag_t;

  // Kernel partial sum for one bit plane: sel[t] is the plane bit of tap t
  function automatic logic signed [4:0] da_entry(input logic [TAPS-1:0] sel);
    int acc;
    acc = 0;
    for (int t = 0; t < TAPS; t++) begin
      if (sel[t]) acc += (t == CENTRE) ? 8 : -1;
    end
    return 5'(acc);
  endfunction

  // Magnitude limited to lim
  function automatic int mag_clamp(input int v, input int lim);
    int m;
    m = (v < 0) ? -v : v;
    return (m > lim) ? lim : m;
  endfunction

endpackage

// File: rtl/lap_da_line.sv
module lap_da_line #(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic             clk,
  input  logic             en_i,
  input  logic [PIX_W-1:0] d_i,
  output logic [PIX_W-1:0] q_o
);

  logic [PIX_W-1:0] sr_q [LINE_W];

  always_ff @(posedge clk) begin
    if (en_i) begin
      sr_q[0] <= d_i;
      for (int i = 1; i < LINE_W; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[LINE_W-1];

endmodule

// File: rtl/lap_da_window.sv
module lap_da_window
  import lap_da_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic                  clk,
  input  logic                  en_i,
  input  logic [PIX_W-1:0]      pix_i,
  output logic [TAPS*PIX_W-1:0] win_o
);

  // Column taps: 0 = current row, 1 = one row up, 2 = two rows up
  logic [PIX_W-1:0] tap [3];
  logic [PIX_W-1:0] w_q [TAPS];

  assign tap[0] = pix_i;

  for (genvar k = 0; k < 2; k++) begin : g_line
    lap_da_line #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_line (
      .clk  (clk),
      .en_i (en_i),
      .d_i  (tap[k]),
      .q_o  (tap[k+1])
    );
  end

  // Window index = row*3 + col, row 0 oldest, col 2 newest
  always_ff @(posedge clk) begin
    if (en_i) begin
      for (int rr = 0; rr < 3; rr++) begin
        w_q[rr*3]     <= w_q[rr*3+1];
        w_q[rr*3+1]   <= w_q[rr*3+2];
        w_q[rr*3+2]   <= tap[2-rr];
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_pack
    assign win_o[t*PIX_W +: PIX_W] = w_q[t];
  end

endmodule

// File: rtl/lap_da_core.sv
module lap_da_core
  import lap_da_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int RES_W = PIX_W + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TAPS*PIX_W-1:0]   win_i,
  output logic signed [RES_W-1:0] sum_o
);

  localparam int LVLS = $clog2(PIX_W);
  localparam int NP   = 1 << LVLS;

  // Heap-ordered nodes: leaves NP..2NP-1 are plane sums, node 1 the total
  logic signed [RES_W-1:0] nd [1:2*NP-1];

  for (genvar b = 0; b < NP; b++) begin : g_plane
    if (b < PIX_W) begin : g_lut
      logic [TAPS-1:0] sel;
      for (genvar t = 0; t < TAPS; t++) begin : g_sel
        assign sel[t] = win_i[t*PIX_W + b];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nd[NP+b] <= '0;
        else        nd[NP+b] <= RES_W'(da_entry(sel));
      end
    end else begin : g_pad
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nd[NP+b] <= '0;
        else        nd[NP+b] <= '0;
      end
    end
  end

  for (genvar i = 1; i < NP; i++) begin : g_node
    localparam int SH = 1 << (LVLS - $clog2(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nd[i] <= '0;
      else        nd[i] <= nd[2*i] + (nd[2*i+1] <<< SH);
    end
  end

  assign sum_o = nd[1];

endmodule

// File: rtl/lap_da_filter.sv
module lap_da_filter
  import lap_da_pkg::*;
#(
  parameter  int PIX_W  = 8,
  parameter  int LINE_W = 64,
  localparam int RES_W  = PIX_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             sof_i,
  input  logic             abs_mode_i,
  output logic             res_vld_o,
  output logic             res_sof_o,
  output logic [RES_W-1:0] res_o
);

  localparam int COL_W = $clog2(LINE_W);
  localparam int LVLS  = $clog2(PIX_W);
  localparam int TAG_D = LVLS + 2;
  localparam int LAT   = LVLS + 3;
  localparam int PMAX  = (1 << PIX_W) - 1;

  // Position tracking
  logic [COL_W-1:0] col_q, cur_col;
  logic [1:0]       row_q, cur_row;
  logic             edge_w;

  always_comb begin
    cur_col = sof_i ? '0 : col_q;
    cur_row = sof_i ? 2'd0 : row_q;
  end
  assign edge_w = (cur_row < 2'd2) || (cur_col < COL_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (pix_vld_i) begin
      if (cur_col == COL_W'(LINE_W - 1)) begin
        col_q <= '0;
        row_q <= (cur_row == 2'd2) ? 2'd2 : cur_row + 2'd1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end

  // Datapath
  logic [TAPS*PIX_W-1:0]   win_w;
  logic signed [RES_W-1:0] sum_w;

  lap_da_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_win (
    .clk   (clk),
    .en_i  (pix_vld_i),
    .pix_i (pix_i),
    .win_o (win_w)
  );

  lap_da_core #(.PIX_W(PIX_W), .RES_W(RES_W)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .win_i (win_w),
    .sum_o (sum_w)
  );

  // Control shift chain matched to window + LUT + tree registers
  tag_t tag_in, tag_q [TAG_D];

  assign tag_in = '{vld: pix_vld_i, sof: pix_vld_i & sof_i,
                    zero: edge_w, abs_m: abs_mode_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < TAG_D; s++) tag_q[s] <= '0;
    end else begin
      tag_q[0] <= tag_in;
      for (int s = 1; s < TAG_D; s++) tag_q[s] <= tag_q[s-1];
    end
  end

  // Output stage
  tag_t             out_tag;
  logic [RES_W-1:0] res_d;
  logic             out_abs_w, out_zero_w;

  always_comb begin
    out_tag = tag_q[TAG_D-1];
    if (!out_tag.vld || out_tag.zero) res_d = '0;
    else if (out_tag.abs_m)           res_d = RES_W'(mag_clamp(int'(sum_w), PMAX));
    else                              res_d = sum_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld_o  <= 1'b0;
      res_sof_o  <= 1'b0;
      res_o      <= '0;
      out_abs_w  <= 1'b0;
      out_zero_w <= 1'b0;
    end else begin
      res_vld_o  <= out_tag.vld;
      res_sof_o  <= out_tag.sof;
      res_o      <= res_d;
      out_abs_w  <= out_tag.abs_m;
      out_zero_w <= out_tag.zero;
    end
  end

endmodule

module lap_da_filter_chk #(
  parameter int PIX_W = 8,
  parameter int LAT   = 6,
  parameter int RES_W = PIX_W + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_vld_i,
  input logic             res_vld_o,
  input logic             res_sof_o,
  input logic [RES_W-1:0] res_o,
  input logic             out_abs_w,
  input logic             out_zero_w
);

  localparam int PMAX = (1 << PIX_W) - 1;
  localparam int LIM  = 8 * PMAX;

  logic [LAT-1:0] hist_q;
  int unsigned    fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= 0;
    end else begin
      hist_q <= {hist_q[LAT-2:0], pix_vld_i};
      if (fill_q < LAT) fill_q <= fill_q + 1;
    end
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q >= LAT) |-> (res_vld_o == hist_q[LAT-1]));

  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_o |-> (res_o == '0));

  assert_border_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && out_zero_w) |-> (res_o == '0));

  assert_abs_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && out_abs_w) |-> (int'(res_o) <= PMAX));

  assert_signed_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_o && !out_abs_w) |->
      (int'($signed(res_o)) <= LIM && int'($signed(res_o)) >= -LIM));

  assert_sof_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_sof_o |-> res_vld_o);

endmodule

bind lap_da_filter lap_da_filter_chk #(.PIX_W(PIX_W), .LAT(LAT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_vld_i  (pix_vld_i),
  .res_vld_o  (res_vld_o),
  .res_sof_o  (res_sof_o),
  .res_o      (res_o),
  .out_abs_w  (out_abs_w),
  .out_zero_w (out_zero_w)
);

// File: tb/lap_da_filter_tb.sv
`timescale 1ns/1ps
module lap_da_filter_tb_top;

  localparam int PW = 8;
  localparam int LW = 8;
  localparam int RW = PW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pix_vld_i, sof_i, abs_mode_i;
  logic [PW-1:0] pix_i;
  logic          res_vld_o, res_sof_o;
  logic [RW-1:0] res_o;

  always #2 clk = ~clk;

  lap_da_filter #(.PIX_W(PW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pix_vld_i(pix_vld_i), .pix_i(pix_i),
    .sof_i(sof_i), .abs_mode_i(abs_mode_i),
    .res_vld_o(res_vld_o), .res_sof_o(res_sof_o), .res_o(res_o)
  );

  typedef struct {
    int    val;
    bit    sof;
    bit    am;
    int    cyc;
    string req;
  } exp_t;

  exp_t        q[$];
  int          checks = 0, failures = 0, cyc = 0;
  int          img [0:31][0:LW-1];
  int          rr = 0, cc = 0;
  string       cur_tag = "R1";
  int unsigned seed = 32'h1234_5678;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  // Laplacian restated as 9*centre minus the full 3x3 sum
  function automatic int model(input int r, input int c, input bit am);
    int s, v;
    if (r < 2 || c < 2) return 0;
    s = 0;
    for (int dr = 0; dr < 3; dr++)
      for (int dc = 0; dc < 3; dc++)
        s += img[r-2+dr][c-2+dc];
    v = 9 * img[r-1][c-1] - s;
    if (am) begin
      if (v < 0) v = -v;
      if (v > 255) v = 255;
    end
    return v;
  endfunction

  task automatic send(input int p, input bit sof, input bit am);
    exp_t e;
    if (sof) begin rr = 0; cc = 0; end
    img[rr][cc] = p;
    e.val = model(rr, cc, am);
    e.sof = sof;
    e.am  = am;
    e.cyc = cyc + 6;
    e.req = (rr < 2 || cc < 2) ? "R3" : (am && cur_tag == "R1") ? "R7" : cur_tag;
    q.push_back(e);
    pix_i = PW'(p); sof_i = sof; abs_mode_i = am; pix_vld_i = 1'b1;
    @(negedge clk);
    pix_vld_i = 1'b0; sof_i = 1'b0;
    if (cc == LW - 1) begin cc = 0; rr++; end
    else cc++;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_vld_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4", 1, 0);
        end else begin
          exp_t e;
          int   act;
          e   = q.pop_front();
          act = e.am ? int'(res_o) : int'($signed(res_o));
          chk(act == e.val, e.req, act, e.val);
          chk(res_sof_o == e.sof, "R8", int'(res_sof_o), int'(e.sof));
          chk(cyc == e.cyc, "R4", cyc, e.cyc);
        end
      end else begin
        chk(res_o == '0, "R6", int'(res_o), 0);
        chk(res_sof_o == 1'b0, "R8", int'(res_sof_o), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=expired expected=completed");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pix_vld_i = 1'b0; sof_i = 1'b0; abs_mode_i = 1'b0; pix_i = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(res_vld_o == 1'b0 && res_sof_o == 1'b0, "R10", int'(res_vld_o), 0);
    chk(res_o == '0, "R10", int'(res_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld_o == 1'b0 && res_o == '0, "R10", int'(res_o), 0);

    // Frame A: dense pseudo-random pixels, signed mode (R1)
    cur_tag = "R1";
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < LW; c++)
        send(rnd(), r == 0 && c == 0, 1'b0);

    // Frame B: idle gaps and per-pixel mode changes (R5, R7)
    cur_tag = "R5";
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < LW; c++) begin
        int g;
        send(rnd(), r == 0 && c == 0, rnd() > 127);
        g = rnd();
        if (g % 3 == 0) repeat (g % 4) @(negedge clk);
      end

    // Extremes: isolated bright point and isolated dark point (R9)
    cur_tag = "R9";
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 5; r++)
        for (int c = 0; c < LW; c++) begin
          bit hit;
          hit = (r == 2 && c == 3);
          if (m % 2 == 0) send(hit ? 255 : 0, r == 0 && c == 0, m >= 2);
          else            send(hit ? 0 : 255, r == 0 && c == 0, m >= 2);
        end

    // Mid-row restart: partial frame, then a new frame (R2, R8)
    cur_tag = "R2";
    for (int k = 0; k < 11; k++) send(rnd(), k == 0, 1'b0);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < LW; c++)
        send((r * 37 + c * 11) & 255, r == 0 && c == 0, 1'b0);

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R4", q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule